// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block decides, in a single combinational pass, whether a far jump or a far call may proceed. It takes the current privilege level, the requestor level carried in the selector, and the type, access bits and privilege level of the descriptor the selector names. When that descriptor is a call gate, it also takes the privilege level, the executable bit and the conforming bit of the code descriptor the gate points at, plus the gate's entry offset and its parameter count.

It returns either a grant or a general-protection fault. On a grant it also returns the privilege level that execution continues at and the entry offset to use. When a gated call moves inward to a more privileged nonconforming segment, it flags a stack switch, gives the index of the inner stack pointer to load, and gives the number of doublewords to copy. Fetching the gate, copying the stack and task switching are done elsewhere. The surrounding sequencer presents one request and reads the result in the same cycle.

Top module: `far_xfer_guard`

## Requirements
- R1: A direct transfer has `descIsSeg`=1. In `descType`, bit 3 marks an executable segment and bit 2 marks a conforming one. Such a transfer is granted exactly when the segment is executable and either `descDpl` equals `curPl`, or the segment is conforming and `descDpl` <= `curPl`. `selRpl` and `isCall` have no effect on this outcome.
- R2: A granted direct transfer keeps `newPl` equal to `curPl`, leaves `stackSwitch` low, and sets `entryOffset` to `farOffset`.
- R3: A target that is not an executable code segment always faults. This covers a direct descriptor with bit 3 clear and a gate whose `tgtExec` is 0.
- R4: With `descIsSeg`=0, only type codes 4'h4 and 4'hC are accepted as call gates. Every other system code faults.
- R5: A gated transfer faults when the larger of `curPl` and `selRpl` exceeds the gate level `descDpl`.
- R6: A gated jump (`isCall`=0) to a nonconforming target also requires `tgtDpl` to equal `curPl`.
- R7: A gated call, or a gated jump to a conforming target, also requires `tgtDpl` <= `curPl`.
- R8: A granted gated call to a nonconforming target with `tgtDpl` < `curPl` drives these outputs: `stackSwitch`=1, `newPl`=`tgtDpl`, `stackIdx`=`tgtDpl` (always 0, 1 or 2), and `copyCount`=`gateParamCnt` (0 to 31; 0 means no copy).
- R9: Every other granted transfer, including any transfer to a conforming target, keeps `newPl`=`curPl` and drives `stackSwitch`=0, `stackIdx`=0 and `copyCount`=0.
- R10: A granted gated transfer takes `entryOffset` from `gateOffset`. `farOffset` has no effect on it.
- R11: On a fault, `allow`=0 and `gpFault`=1. In the same case `newPl`=`curPl`, and `stackSwitch`, `stackIdx`, `copyCount` and `entryOffset` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curPl | input | 2 | Current privilege level |
| selRpl | input | 2 | Requestor level from the selector |
| isCall | input | 1 | 1 = far call, 0 = far jump |
| descIsSeg | input | 1 | 1 = code/data segment descriptor, 0 = system descriptor |
| descType | input | 4 | Descriptor type field |
| descDpl | input | 2 | Privilege level of the referenced descriptor (segment or gate) |
| tgtExec | input | 1 | Gate target is an executable segment |
| tgtConf | input | 1 | Gate target is conforming |
| tgtDpl | input | 2 | Privilege level of the gate target |
| gateParamCnt | input | 5 | Gate parameter count in doublewords |
| gateOffset | input | 32 | Entry offset held in the gate |
| farOffset | input | 32 | Offset part of the far pointer |
| allow | output | 1 | Transfer granted |
| gpFault | output | 1 | General-protection fault |
| newPl | output | 2 | Privilege level after the transfer |
| stackSwitch | output | 1 | Inner stack must be loaded |
| stackIdx | output | 2 | Inner stack pointer index |
| copyCount | output | 5 | Doublewords to copy to the new stack |
| entryOffset | output | 32 | Offset to continue execution at |

## Verification
The sweep covers every combination of the two current levels, the gate and target levels, call versus jump, the conforming bit and the executable bit, across six descriptor shapes. It goes after four corner cases:
- A conforming target reached through a gated call must not lower the level. A design that lowers it there would switch stacks.
- A requestor level that sits above an otherwise reachable gate level must fault. A design that compares only the current level would grant the transfer.
- A gated jump to an inner nonconforming target must fault. A design that used the call rule for jumps would grant it.
- On a gated transfer the far pointer's offset must be ignored. A design that leaks it would return the wrong entry offset.

// File: rtl/far_xfer_pkg.sv
package far_xfer_pkg;
  localparam int PL_W = 2;
  typedef logic [PL_W-1:0] pl_t;

  // type-field bit positions for code/data segments
  localparam int EXEC_BIT = 3;
  localparam int CONF_BIT = 2;

  // system codes accepted as call gates
  localparam logic [3:0] GATE_CODE_NARROW = 4'h4;
  localparam logic [3:0] GATE_CODE_WIDE   = 4'hC;

  // comparison results from the level comparator
  typedef struct packed {
    logic directEq;   // descriptor level == current level
    logic directLe;   // descriptor level <= current level
    logic gateReach;  // max(current, requestor) <= gate level
    logic targetEq;   // gate target level == current level
    logic targetLe;   // gate target level <= current level
    logic targetLt;   // gate target level <  current level
  } plCmp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic grant;
    logic viaGate;
    logic lowerLevel;
  } xferStrobe_t;

  function automatic pl_t plMax(input pl_t a, input pl_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pl_compare.sv
module pl_compare
  import far_xfer_pkg::*;
(
  input  pl_t    curPl,
  input  pl_t    selRpl,
  input  pl_t    descDpl,
  input  pl_t    tgtDpl,
  output plCmp_t cmp
);
  pl_t effPl;

  always_comb begin
    effPl         = plMax(curPl, selRpl);
    cmp.directEq  = (descDpl == curPl);
    cmp.directLe  = (descDpl <= curPl);
    cmp.gateReach = (effPl <= descDpl);
    cmp.targetEq  = (tgtDpl == curPl);
    cmp.targetLe  = (tgtDpl <= curPl);
    cmp.targetLt  = (tgtDpl < curPl);
  end
endmodule

// File: rtl/xfer_rule_ctrl.sv
module xfer_rule_ctrl
  import far_xfer_pkg::*;
(
  input  plCmp_t      cmp,
  input  logic        isCall,
  input  logic        descIsSeg,
  input  logic [3:0]  descType,
  input  logic        tgtExec,
  input  logic        tgtConf,
  output xferStrobe_t strobe
);
  logic isExecSeg;
  logic segConf;
  logic isGate;
  logic directOk;
  logic strictTarget;
  logic targetRule;
  logic gatedOk;

  always_comb begin
    isExecSeg    = descIsSeg && descType[EXEC_BIT];
    segConf      = descType[CONF_BIT];
    isGate       = !descIsSeg &&
                   ((descType == GATE_CODE_NARROW) || (descType == GATE_CODE_WIDE));
    directOk     = isExecSeg && (cmp.directEq || (segConf && cmp.directLe));
    // jump into a nonconforming target must stay at the same level
    strictTarget = !isCall && !tgtConf;
    targetRule   = strictTarget ? cmp.targetEq : cmp.targetLe;
    gatedOk      = isGate && tgtExec && cmp.gateReach && targetRule;

    strobe.grant      = directOk || gatedOk;
    strobe.viaGate    = isGate;
    strobe.lowerLevel = gatedOk && isCall && !tgtConf && cmp.targetLt;
  end
endmodule

// File: rtl/xfer_level_path.sv
module xfer_level_path
  import far_xfer_pkg::*;
#(
  parameter int OFS_W = 32,
  parameter int CNT_W = 5
) (
  input  xferStrobe_t      strobe,
  input  pl_t              curPl,
  input  pl_t              tgtDpl,
  input  logic [CNT_W-1:0] gateParamCnt,
  input  logic [OFS_W-1:0] gateOffset,
  input  logic [OFS_W-1:0] farOffset,
  output pl_t              newPl,
  output pl_t              stackIdx,
  output logic [CNT_W-1:0] copyCount,
  output logic [OFS_W-1:0] entryOffset
);
  always_comb begin
    newPl     = strobe.lowerLevel ? tgtDpl : curPl;
    stackIdx  = strobe.lowerLevel ? tgtDpl : '0;
    copyCount = strobe.lowerLevel ? gateParamCnt : '0;
    if (!strobe.grant)
      entryOffset = '0;
    else if (strobe.viaGate)
      entryOffset = gateOffset;
    else
      entryOffset = farOffset;
  end
endmodule

// File: rtl/far_xfer_guard.sv
module far_xfer_guard
  import far_xfer_pkg::*;
#(
  parameter int OFS_W = 32,
  parameter int CNT_W = 5
) (
  input  logic [1:0]       curPl,
  input  logic [1:0]       selRpl,
  input  logic             isCall,
  input  logic             descIsSeg,
  input  logic [3:0]       descType,
  input  logic [1:0]       descDpl,
  input  logic             tgtExec,
  input  logic             tgtConf,
  input  logic [1:0]       tgtDpl,
  input  logic [CNT_W-1:0] gateParamCnt,
  input  logic [OFS_W-1:0] gateOffset,
  input  logic [OFS_W-1:0] farOffset,
  output logic             allow,
  output logic             gpFault,
  output logic [1:0]       newPl,
  output logic             stackSwitch,
  output logic [1:0]       stackIdx,
  output logic [CNT_W-1:0] copyCount,
  output logic [OFS_W-1:0] entryOffset
);
  plCmp_t      cmp;
  xferStrobe_t strobe;

  pl_compare cmp_i (
    .curPl  (curPl),
    .selRpl (selRpl),
    .descDpl(descDpl),
    .tgtDpl (tgtDpl),
    .cmp    (cmp)
  );

  xfer_rule_ctrl ctrl_i (
    .cmp      (cmp),
    .isCall   (isCall),
    .descIsSeg(descIsSeg),
    .descType (descType),
    .tgtExec  (tgtExec),
    .tgtConf  (tgtConf),
    .strobe   (strobe)
  );

  xfer_level_path #(.OFS_W(OFS_W), .CNT_W(CNT_W)) path_i (
    .strobe      (strobe),
    .curPl       (curPl),
    .tgtDpl      (tgtDpl),
    .gateParamCnt(gateParamCnt),
    .gateOffset  (gateOffset),
    .farOffset   (farOffset),
    .newPl       (newPl),
    .stackIdx    (stackIdx),
    .copyCount   (copyCount),
    .entryOffset (entryOffset)
  );

  assign allow       = strobe.grant;
  assign gpFault     = !strobe.grant;
  assign stackSwitch = strobe.lowerLevel;
endmodule

// File: rtl/far_xfer_guard_chk.sv
module far_xfer_guard_chk #(
  parameter int OFS_W = 32,
  parameter int CNT_W = 5
) (
  input logic [1:0]       curPl,
  input logic [1:0]       selRpl,
  input logic             isCall,
  input logic             descIsSeg,
  input logic [3:0]       descType,
  input logic [1:0]       descDpl,
  input logic [CNT_W-1:0] gateParamCnt,
  input logic [OFS_W-1:0] gateOffset,
  input logic             allow,
  input logic             gpFault,
  input logic [1:0]       newPl,
  input logic             stackSwitch,
  input logic [1:0]       stackIdx,
  input logic [CNT_W-1:0] copyCount,
  input logic [OFS_W-1:0] entryOffset
);
  logic [1:0] effPl;
  assign effPl = (curPl > selRpl) ? curPl : selRpl;

  always_comb begin
    p_fault_quiet_r11: assert (!gpFault ||
      (!stackSwitch && stackIdx == 2'd0 && copyCount == '0 &&
       entryOffset == '0 && newPl == curPl))
      else $error("fault outputs not quiet");
    p_switch_inward_r8: assert (!stackSwitch ||
      (allow && isCall && newPl < curPl && stackIdx == newPl &&
       copyCount == gateParamCnt))
      else $error("stack switch inconsistent");
    p_level_kept_r9: assert (!(allow && !stackSwitch) ||
      (newPl == curPl && stackIdx == 2'd0 && copyCount == '0))
      else $error("level changed without stack switch");
    p_nonexec_fault_r3: assert (!(descIsSeg && !descType[3]) || gpFault)
      else $error("non-executable segment granted");
    p_gate_reach_r5: assert (!(!descIsSeg && effPl > descDpl) || gpFault)
      else $error("gate above reach granted");
    p_gate_entry_r10: assert (!(allow && !descIsSeg) || entryOffset == gateOffset)
      else $error("gated entry not from gate");
  end
endmodule

bind far_xfer_guard far_xfer_guard_chk #(.OFS_W(OFS_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/far_xfer_guard_tb_top.sv
module far_xfer_guard_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [1:0]  curPl = '0, selRpl = '0, descDpl = '0, tgtDpl = '0;
  logic        isCall = 0, descIsSeg = 0, tgtExec = 0, tgtConf = 0;
  logic [3:0]  descType = '0;
  logic [4:0]  gateParamCnt = '0;
  logic [31:0] gateOffset = '0, farOffset = '0;
  logic        allow, gpFault, stackSwitch;
  logic [1:0]  newPl, stackIdx;
  logic [4:0]  copyCount;
  logic [31:0] entryOffset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  far_xfer_guard dut_i (.*);

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, compared after every applied request
  task automatic compare();
    int cpl, rpl, dpl, tdl, mx;
    bit seg, gated, ok, sw, exe, conf;
    string tA, tL, tE;
    cpl = curPl; rpl = selRpl; dpl = descDpl; tdl = tgtDpl;
    mx = (cpl > rpl) ? cpl : rpl;
    seg = descIsSeg;
    exe = descType[3]; conf = descType[2];
    gated = !seg && (descType == 4 || descType == 12);
    ok = 0;
    if (seg) begin
      ok = exe && (dpl == cpl || (conf && dpl <= cpl));
      tA = exe ? "R1" : "R3";
    end else if (!gated) begin
      tA = "R4";
    end else begin
      if (!tgtExec) tA = "R3";
      else if (mx > dpl) tA = "R5";
      else if (!isCall && !tgtConf) tA = "R6";
      else tA = "R7";
      ok = tgtExec && (mx <= dpl) &&
           ((!isCall && !tgtConf) ? (tdl == cpl) : (tdl <= cpl));
    end
    sw = ok && gated && isCall && !tgtConf && (tdl < cpl);
    tL = !ok ? "R11" : sw ? "R8" : "R9";
    tE = !ok ? "R11" : gated ? "R10" : "R2";
    check(tA, "allow", allow, ok);
    check(tA, "gpFault", gpFault, !ok);
    check(tL, "newPl", newPl, sw ? tdl : cpl);
    check(tL, "stackSwitch", stackSwitch, sw);
    check(tL, "stackIdx", stackIdx, sw ? tdl : 0);
    check(tL, "copyCount", copyCount, sw ? gateParamCnt : 0);
    check(tE, "entryOffset", entryOffset,
          !ok ? 0 : gated ? gateOffset : farOffset);
  endtask

  task automatic apply(input int cpl, input int rpl, input bit call, input bit seg,
                       input int typ, input int dpl, input bit tx, input bit tc,
                       input int tdl, input int cnt, input int gofs, input int fofs);
    @(posedge clk);
    curPl = 2'(cpl); selRpl = 2'(rpl); isCall = call; descIsSeg = seg;
    descType = 4'(typ); descDpl = 2'(dpl); tgtExec = tx; tgtConf = tc;
    tgtDpl = 2'(tdl); gateParamCnt = 5'(cnt);
    gateOffset = 32'(gofs); farOffset = 32'(fofs);
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    // idle inputs: system code 0 must fault (R4, R11)
    check("R11", "idle gpFault", gpFault, 1);
    check("R11", "idle entryOffset", entryOffset, 0);

    // R1: conforming inner segment reached directly, level kept (R9)
    apply(3, 0, 1, 1, 4'hE, 1, 0, 0, 0, 0, 0, 32'h1234);
    check("R1", "conforming direct allow", allow, 1);
    check("R9", "conforming keeps level", newPl, 3);
    // R1: RPL ignored on direct transfer
    apply(1, 3, 0, 1, 4'hA, 1, 0, 0, 0, 0, 0, 32'h55);
    check("R1", "rpl ignored", allow, 1);
    // R3: data segment faults
    apply(0, 0, 1, 1, 4'h2, 0, 1, 0, 0, 0, 0, 7);
    check("R3", "data target fault", gpFault, 1);
    // R4: system code 9 faults
    apply(0, 0, 1, 0, 4'h9, 3, 1, 0, 0, 0, 0, 7);
    check("R4", "non-gate system fault", gpFault, 1);
    // R8: inward call, 31 params
    apply(3, 3, 1, 0, 4'hC, 3, 1, 0, 0, 31, 32'hABCD, 32'h9);
    check("R8", "switch", stackSwitch, 1);
    check("R8", "stackIdx", stackIdx, 0);
    check("R8", "copyCount max", copyCount, 31);
    check("R10", "gate entry", entryOffset, 32'hABCD);
    // R7: gated call to conforming inner keeps level
    apply(2, 0, 1, 0, 4'h4, 3, 1, 1, 0, 9, 32'h77, 32'h9);
    check("R7", "conf gated call allow", allow, 1);
    check("R9", "conf gated no switch", stackSwitch, 0);
    // R6: gated jump inward to nonconforming faults
    apply(2, 0, 0, 0, 4'hC, 3, 1, 0, 1, 4, 32'h77, 32'h9);
    check("R6", "gated jump inward", gpFault, 1);
    // R5: requestor level above gate
    apply(1, 3, 1, 0, 4'hC, 2, 1, 0, 0, 4, 32'h77, 32'h9);
    check("R5", "rpl above gate", gpFault, 1);

    // full sweep
    for (int kind = 0; kind < 6; kind++)
      for (int cpl = 0; cpl < 4; cpl++)
        for (int rpl = 0; rpl < 4; rpl++)
          for (int dpl = 0; dpl < 4; dpl++)
            for (int tdl = 0; tdl < 4; tdl++)
              for (int f = 0; f < 8; f++) begin
                bit seg;
                int typ;
                case (kind)
                  0: begin seg = 1; typ = 4'hA; end
                  1: begin seg = 1; typ = 4'hE; end
                  2: begin seg = 1; typ = 4'h2; end
                  3: begin seg = 0; typ = 4'hC; end
                  4: begin seg = 0; typ = 4'h4; end
                  default: begin seg = 0; typ = 4'h9; end
                endcase
                apply(cpl, rpl, f[0], seg, typ, dpl, f[1], f[2], tdl,
                      (cpl * 7 + tdl * 3 + f) % 32,
                      32'h1000 + kind * 256 + f,
                      32'h8000 + cpl * 16 + dpl);
              end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule